// File: doc/BRIEF.md
# Split I/D L1 Request Dispatcher

This block sits between the processor's request queue and a pair of split first-level caches, one for instructions and one for data. Each cycle it looks at the request at the head of the queue and decodes its kind. It looks up the indexed set in both caches' tag arrays and raises exactly one event toward the line controller. An instruction fetch is aimed at the instruction cache, and every other kind of request is aimed at the data cache.

There are three possible outcomes. If the requested line sits in the cache opposite the target, the block first orders a writeback of that line. Otherwise it issues an access event: either the tag hits, or a free way exists in the target set and is named as the fill way. If the target set is full, it issues a replacement event that names the least recently used line of that set. The request leaves the queue only when the controller accepts an access event. After a writeback or a replacement, the request stays at the head of the queue and is decoded again.

Top module: `l1_split_dispatch`

## Requirements
- R1: Request kind codes map to event codes as follows. Load (kind 0) maps to event 0. Instruction fetch (kind 1) maps to event 1. Store (kind 2) and atomic (kind 3) both map to event 2.
- R2: An instruction fetch targets the instruction cache (`evt_cache`=1). Every other valid kind targets the data cache (`evt_cache`=0).
- R3: If the requested tag is valid in the opposite cache, a writeback event (code 3) is raised. It carries the requested address, names the opposite cache, gives the way that holds the line, and takes priority over every other outcome. The line must never be valid in both caches at once.
- R4: A tag hit in the target cache raises the mapped access event for the requested address, naming the way that hit.
- R5: A miss in a target set that has at least one invalid way raises the mapped access event and names the lowest-numbered invalid way.
- R6: A miss in a full target set raises a replacement event (code 4). Its address is the victim way's tag followed by the set index, with the offset bits zeroed.
- R7: A request kind above 3 raises no event, asserts `req_err`, and is popped.
- R8: `req_ready` is high only when an access event is accepted (`evt_ready` high) or when the kind is illegal. Writeback events, replacement events and stalled access events never pop the request, and nothing is popped while `req_valid` is low or reset is active.
- R9: Each cache keeps a least-recently-used order for every set. After reset, way w has age w, so the highest way is the first victim. An accepted access makes its named way the most recent. The victim is always the way that was touched least recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Head of the processor queue holds a request |
| req_kind | input | 3 | Request kind: 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr | input | ADDR_W | Requested byte address |
| req_ready | output | 1 | Pop the head of the queue this cycle |
| req_err | output | 1 | Illegal request kind |
| dc_set | output | IDX_W | Set index presented to the data-cache tags |
| dc_way_vld | input | WAYS | Per-way valid bits of that data-cache set |
| dc_way_tag | input | WAYS*TAG_W | Per-way tags of that data-cache set, way w at bits w*TAG_W |
| ic_set | output | IDX_W | Set index presented to the instruction-cache tags |
| ic_way_vld | input | WAYS | Per-way valid bits of that instruction-cache set |
| ic_way_tag | input | WAYS*TAG_W | Per-way tags of that instruction-cache set |
| evt_valid | output | 1 | Event offered to the line controller |
| evt_ready | input | 1 | Line controller takes the event |
| evt_kind | output | 3 | Event code: 0 load, 1 fetch, 2 store, 3 writeback, 4 replace |
| evt_cache | output | 1 | Cache the event acts on: 0 data, 1 instruction |
| evt_addr | output | ADDR_W | Line address the event acts on |
| evt_way | output | WAY_W | Way the event acts on |

## Verification
Every event field, `req_ready` and `req_err` is combinational from the queue head and the returned tags. The bench therefore drives each stimulus on a falling edge and samples one nanosecond later, within the same cycle. The order state is the only register. A touch lands on the rising edge that accepts the access, so its effect on victim choice is checked in the following cycle. The bench sequences hits and misses on one set and checks the replacement address after each touch.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  // request kinds at the queue head
  localparam logic [2:0] RQ_LOAD   = 3'd0;
  localparam logic [2:0] RQ_FETCH  = 3'd1;
  localparam logic [2:0] RQ_STORE  = 3'd2;
  localparam logic [2:0] RQ_ATOMIC = 3'd3;

  typedef enum logic [2:0] {
    EV_LOAD    = 3'd0,
    EV_FETCH   = 3'd1,
    EV_STORE   = 3'd2,
    EV_WRBACK  = 3'd3,
    EV_REPLACE = 3'd4
  } evt_e;
endpackage

// File: rtl/l1d_tag_match.sv
module l1d_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  has_free,
  output logic [WAY_W-1:0]      free_way
);
  logic [WAYS-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_vld[g] && (way_tag[g*TAG_W +: TAG_W] == look_tag);
    end
  endgenerate

  always_comb begin
    hit      = |hit_vec;
    has_free = ~&way_vld;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (!way_vld[w]) free_way = WAY_W'(w);
    end
  end

  // R4: a tag may match in at most one way of a set
  a_r4_hit_unique: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/l1d_lru_table.sv
module l1d_lru_table #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] oldest_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] cur   [WAYS];
  logic [WAY_W-1:0] nxt   [WAYS];
  logic [WAYS-1:0]  oldest_mask;

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      cur[w]         = age_q[set_idx][w];
      oldest_mask[w] = (cur[w] == WAY_W'(WAYS - 1));
      if (oldest_mask[w]) oldest_way = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)    nxt[w] = '0;
      else if (cur[w] < cur[touch_way]) nxt[w] = cur[w] + 1'b1;
      else                           nxt[w] = cur[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[set_idx][w] <= nxt[w];
    end
  end

  // R9: the ages of a set stay a permutation, so exactly one way is oldest
  a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_mask) == 1);
endmodule

// File: rtl/l1_split_dispatch.sv
module l1_split_dispatch
  import l1d_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [2:0]            req_kind,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  req_ready,
  output logic                  req_err,
  output logic [IDX_W-1:0]      dc_set,
  input  logic [WAYS-1:0]       dc_way_vld,
  input  logic [WAYS*TAG_W-1:0] dc_way_tag,
  output logic [IDX_W-1:0]      ic_set,
  input  logic [WAYS-1:0]       ic_way_vld,
  input  logic [WAYS*TAG_W-1:0] ic_way_tag,
  output logic                  evt_valid,
  input  logic                  evt_ready,
  output logic [2:0]            evt_kind,
  output logic                  evt_cache,
  output logic [ADDR_W-1:0]     evt_addr,
  output logic [WAY_W-1:0]      evt_way
);
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             is_fetch, kind_ok, live;
  logic             d_hit, d_free, i_hit, i_free;
  logic [WAY_W-1:0] d_hit_way, d_free_way, i_hit_way, i_free_way;
  logic [WAY_W-1:0] d_old, i_old;
  logic             t_hit, t_free, o_hit;
  logic [WAY_W-1:0] t_hit_way, t_free_way, o_hit_way, t_old;
  logic [WAYS*TAG_W-1:0] t_tags;
  logic             is_access, accept;
  logic [2:0]       acc_code;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign dc_set   = req_idx;
  assign ic_set   = req_idx;
  assign is_fetch = (req_kind == RQ_FETCH);
  assign kind_ok  = (req_kind <= RQ_ATOMIC);
  assign live     = req_valid && rst_n;

  l1d_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_dtag (
    .clk(clk), .rst_n(rst_n), .chk_en(req_valid),
    .way_vld(dc_way_vld), .way_tag(dc_way_tag), .look_tag(req_tag),
    .hit(d_hit), .hit_way(d_hit_way), .has_free(d_free), .free_way(d_free_way));

  l1d_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_itag (
    .clk(clk), .rst_n(rst_n), .chk_en(req_valid),
    .way_vld(ic_way_vld), .way_tag(ic_way_tag), .look_tag(req_tag),
    .hit(i_hit), .hit_way(i_hit_way), .has_free(i_free), .free_way(i_free_way));

  // touches only reach the order table of the target cache
  logic d_touch, i_touch;
  assign accept  = evt_valid && evt_ready && is_access;
  assign d_touch = accept && !is_fetch;
  assign i_touch = accept && is_fetch;

  l1d_lru_table #(.SETS(SETS), .WAYS(WAYS)) u_dlru (
    .clk(clk), .rst_n(rst_n), .set_idx(req_idx),
    .touch_en(d_touch), .touch_way(evt_way), .oldest_way(d_old));

  l1d_lru_table #(.SETS(SETS), .WAYS(WAYS)) u_ilru (
    .clk(clk), .rst_n(rst_n), .set_idx(req_idx),
    .touch_en(i_touch), .touch_way(evt_way), .oldest_way(i_old));

  // select target / opposite views
  always_comb begin
    if (is_fetch) begin
      t_hit = i_hit; t_hit_way = i_hit_way; t_free = i_free; t_free_way = i_free_way;
      t_old = i_old; t_tags = ic_way_tag; o_hit = d_hit; o_hit_way = d_hit_way;
    end else begin
      t_hit = d_hit; t_hit_way = d_hit_way; t_free = d_free; t_free_way = d_free_way;
      t_old = d_old; t_tags = dc_way_tag; o_hit = i_hit; o_hit_way = i_hit_way;
    end
    case (req_kind)
      RQ_LOAD:  acc_code = EV_LOAD;
      RQ_FETCH: acc_code = EV_FETCH;
      default:  acc_code = EV_STORE;
    endcase
  end

  // event decision, priority: illegal, writeback, hit, free fill, replace
  always_comb begin
    evt_valid = 1'b0;
    evt_kind  = acc_code;
    evt_cache = is_fetch;
    evt_addr  = req_addr;
    evt_way   = t_hit_way;
    is_access = 1'b0;
    req_err   = 1'b0;
    if (live) begin
      if (!kind_ok) begin
        req_err = 1'b1;
      end else if (o_hit) begin
        evt_valid = 1'b1;
        evt_kind  = EV_WRBACK;
        evt_cache = !is_fetch;
        evt_way   = o_hit_way;
      end else if (t_hit) begin
        evt_valid = 1'b1;
        is_access = 1'b1;
      end else if (t_free) begin
        evt_valid = 1'b1;
        is_access = 1'b1;
        evt_way   = t_free_way;
      end else begin
        evt_valid = 1'b1;
        evt_kind  = EV_REPLACE;
        evt_way   = t_old;
        evt_addr  = {t_tags[t_old*TAG_W +: TAG_W], req_idx, {OFF_W{1'b0}}};
      end
    end
  end

  assign req_ready = req_err || accept;

  // R3: a line is never resident in both caches
  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind_ok) |-> !(d_hit && i_hit));

  // R8: a legal request leaves the queue only with a handshake on the event side
  a_r8_pop_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_err) |-> (evt_valid && evt_ready && evt_kind <= 3'd2));

  // R7: illegal kinds raise no event
  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!evt_valid && req_ready));

  // R6: a replacement is only offered for a full target set
  a_r6_victim_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd4) |-> (evt_cache ? &ic_way_vld : &dc_way_vld));
endmodule

// File: tb/l1_split_dispatch_bench.sv
module l1_split_dispatch_bench;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_err;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [3:0]  dc_set, ic_set;
  logic [3:0]  dc_way_vld, ic_way_vld;
  logic [31:0] dc_way_tag, ic_way_tag;
  logic        evt_valid, evt_ready, evt_cache;
  logic [2:0]  evt_kind;
  logic [15:0] evt_addr;
  logic [1:0]  evt_way;

  int n_run, n_fail;
  bit done;

  l1_split_dispatch u_l1_split_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ready(req_ready), .req_err(req_err),
    .dc_set(dc_set), .dc_way_vld(dc_way_vld), .dc_way_tag(dc_way_tag),
    .ic_set(ic_set), .ic_way_vld(ic_way_vld), .ic_way_tag(ic_way_tag),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_cache(evt_cache), .evt_addr(evt_addr), .evt_way(evt_way));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [3:0]  dv;
    logic [31:0] dt;
    logic [3:0]  iv;
    logic [31:0] it;
    logic        rdy;
    logic        e_vld;
    logic [2:0]  e_kind;
    logic        e_cache;
    logic [15:0] e_addr;
    logic [1:0]  e_way;
    logic        e_pop;
    logic        e_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    // R4 load hit in D way1, R1 code 0
    '{4'd4, 3'd0, 16'h1230, 4'b0010, 32'h00001200, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd0, 1'b0, 16'h1230, 2'd1, 1'b1, 1'b0},
    // R5 fetch miss into empty I set, lowest free way 0 (also R2)
    '{4'd5, 3'd1, 16'h4550, 4'b0000, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd1, 1'b1, 16'h4550, 2'd0, 1'b1, 1'b0},
    // R6 store miss full D set, reset victim way3 tag 13
    '{4'd6, 3'd2, 16'h7861, 4'b1111, 32'h13121110, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd4, 1'b0, 16'h1360, 2'd3, 1'b0, 1'b0},
    // R1 atomic maps to store, hit D way2
    '{4'd1, 3'd3, 16'h9A72, 4'b0100, 32'h009A0000, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd2, 1'b0, 16'h9A72, 2'd2, 1'b1, 1'b0},
    // R3 load finds line in I cache: writeback from I, no pop
    '{4'd3, 3'd0, 16'hBC80, 4'b0000, 32'h0, 4'b0001, 32'h000000BC, 1'b1, 1'b1, 3'd3, 1'b1, 16'hBC80, 2'd0, 1'b0, 1'b0},
    // R3 fetch finds line in D; writeback wins over full I set
    '{4'd3, 3'd1, 16'hDE90, 4'b1000, 32'hDE000000, 4'b1111, 32'h04030201, 1'b1, 1'b1, 3'd3, 1'b0, 16'hDE90, 2'd3, 1'b0, 1'b0},
    // R7 illegal kind 5
    '{4'd7, 3'd5, 16'h0000, 4'b0000, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0, 2'd0, 1'b1, 1'b1},
    // R8 load hit offered while controller stalls: no pop
    '{4'd8, 3'd0, 16'h11A0, 4'b0001, 32'h00000011, 4'b0000, 32'h0, 1'b0, 1'b1, 3'd0, 1'b0, 16'h11A0, 2'd0, 1'b0, 1'b0},
    // R5 store miss with ways 0,1 busy: fill way 2
    '{4'd5, 3'd2, 16'h22B0, 4'b0011, 32'h00000504, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd2, 1'b0, 16'h22B0, 2'd2, 1'b1, 1'b0},
    // R2 fetch hit in I way3
    '{4'd2, 3'd1, 16'h33C0, 4'b0000, 32'h0, 4'b1000, 32'h33000000, 1'b1, 1'b1, 3'd1, 1'b1, 16'h33C0, 2'd3, 1'b1, 1'b0},
    // R6 atomic miss full D set E, victim way3 tag 63
    '{4'd6, 3'd3, 16'h99E4, 4'b1111, 32'h63626160, 4'b0000, 32'h0, 1'b1, 1'b1, 3'd4, 1'b0, 16'h63E0, 2'd3, 1'b0, 1'b0},
    // R7 illegal kind 7
    '{4'd7, 3'd7, 16'h5555, 4'b0000, 32'h0, 4'b0000, 32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0, 2'd0, 1'b1, 1'b1}
  };

  task automatic drive(input logic [2:0] k, input logic [15:0] a,
                       input logic [3:0] dv, input logic [31:0] dt,
                       input logic [3:0] iv, input logic [31:0] it, input logic rdy);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    dc_way_vld = dv; dc_way_tag = dt; ic_way_vld = iv; ic_way_tag = it;
    evt_ready = rdy;
    #1;
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0;
    dc_way_vld = '0; dc_way_tag = '0; ic_way_vld = '0; ic_way_tag = '0;
    evt_ready = 1'b1;
    // R8: reset holds everything quiet even with a request waiting
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h1230;
    #1;
    check("R8 reset", {29'd0, evt_valid, req_ready, req_err}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    #1;
    check("R8 idle", {30'd0, evt_valid, req_ready}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].kind, TBL[i].addr, TBL[i].dv, TBL[i].dt, TBL[i].iv, TBL[i].it, TBL[i].rdy);
      if (TBL[i].e_vld)
        check($sformatf("R%0d vec%0d", TBL[i].rq, i),
              {3'd0, evt_valid, evt_kind, evt_cache, evt_addr, evt_way, req_ready, req_err, 4'd0},
              {3'd0, 1'b1, TBL[i].e_kind, TBL[i].e_cache, TBL[i].e_addr, TBL[i].e_way,
               TBL[i].e_pop, TBL[i].e_err, 4'd0});
      else
        check($sformatf("R%0d vec%0d", TBL[i].rq, i),
              {29'd0, evt_valid, req_ready, req_err}, {29'd0, 1'b0, TBL[i].e_pop, TBL[i].e_err});
    end

    // R9: order tracking in D set D, full with tags A0..A3
    drive(3'd2, 16'h77D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    check("R9 reset victim", {evt_kind, evt_addr, 6'd0, evt_way}, {3'd4, 16'hA3D0, 6'd0, 2'd3});
    drive(3'd0, 16'hA3D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    check("R9 touch way3", {req_ready, evt_way}, {1'b1, 2'd3});
    drive(3'd2, 16'h77D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    check("R9 victim after one touch", {evt_kind, evt_addr}, {3'd4, 16'hA2D0});
    drive(3'd0, 16'hA0D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    drive(3'd3, 16'hA2D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    drive(3'd2, 16'h77D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    check("R9 victim after three touches", {evt_kind, evt_addr, 6'd0, evt_way}, {3'd4, 16'hA1D0, 6'd0, 2'd1});
    // R9/R8: a stalled access must not touch the order
    drive(3'd0, 16'hA1D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b0);
    drive(3'd2, 16'h77D0, 4'hF, 32'hA3A2A1A0, 4'h0, 32'h0, 1'b1);
    check("R9 stall leaves order", {evt_addr, 14'd0, evt_way}, {16'hA1D0, 14'd0, 2'd1});
    // R9: I cache order is independent of D touches in same set index
    drive(3'd1, 16'h77D0, 4'h0, 32'h0, 4'hF, 32'hB3B2B1B0, 1'b1);
    check("R9 I order separate", {evt_kind, evt_cache, evt_addr}, {3'd4, 1'b1, 16'hB3D0});

    @(negedge clk);
    req_valid = 1'b0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule